// File: doc/BRIEF.md
# Interrupt Post, Mask and Clear Controller

This block gathers interrupt events for a small microcontroller. Each hardware event pulse sets a per-source posted flag. A posted flag turns into a pending request only while that source's enable bit in its mask register is set. Masking never stops a flag from being posted. Software reaches the block through a byte-wide register port. Each group of sources has one status register that shows the posted flags and one mask register. A control register holds a global software-interrupt mode bit.

The status registers behave in two ways, selected by the mode bit. With the mode bit clear, a 0 written to a status bit clears that flag and a 1 does nothing. With the mode bit set, a 1 written to a status bit posts that interrupt and a 0 does nothing. A registered fixed-priority encoder reduces the pending vector to an any-pending flag and the index of the lowest-numbered pending source.

The block carries no streaming data. Every register access completes in the cycle it is presented, so the port has no back-pressure. Reads are combinational and never change state.

Sources are numbered group*8 + bit. Group 0 holds sources 0 to 7 and group 1 holds sources 8 to 15. Group 2 holds sources 16 to 21: bit 0 is timer capture 1, bit 1 is 16-bit counter wrap, bit 2 is external INT2, bit 3 is serial-data-low detect, bit 4 is port-2 GPIO and bit 5 is port-3 GPIO. Bits 7 and 6 of group 2 are reserved.

Top module: `intc_post_mask`

## Requirements
- R1: After reset, all posted flags, mask bits and the mode bit are 0, every register reads 0, pending is 0 and irq_any is 0.
- R2: A 1 on hw_event[i] sets posted flag i at the next clock edge whatever its mask bit is. Flag i reads back as bit (i mod 8) of the status register for group (i div 8). The status registers sit at addresses 0xDA, 0xDB and 0xDC for groups 0, 1 and 2.
- R3: pending[i] is 1 exactly when posted flag i and mask bit i are both 1. The mask registers sit at 0xE0 for group 0, 0xE1 for group 1 and 0xDF for group 2. Each mask register reads back as written.
- R4: While the mode bit is 0, writing 0 to a status-register bit clears that posted flag, and writing 1 leaves it unchanged.
- R5: While the mode bit is 1, writing 1 to a status-register bit sets that posted flag, and writing 0 leaves it unchanged.
- R6: The mode bit is bit 7 of the control register at 0xDE. Bits 6 to 0 of that register read 0 and ignore writes.
- R7: When a hardware event and a clearing write reach the same flag in the same cycle, the event wins and the flag ends up set.
- R8: Bits 7 and 6 of the group-2 status and mask registers read 0 and ignore all writes. Any address outside the seven listed ones reads 0.
- R9: One clock after pending changes, irq_any shows whether pending is nonzero and irq_index shows the lowest i with pending[i] = 1.
- R10: Reading a register leaves the posted flags, mask bits and mode bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| hw_event | input | 22 | Hardware event pulses, one per source |
| pending | output | 22 | Posted flags gated by their mask bits |
| irq_any | output | 1 | Registered flag: at least one source pending |
| irq_index | output | 5 | Registered index of the lowest pending source |

## Verification
The hardest case to reach is a hardware event arriving in the same cycle as a clearing write to the same bit. The bench's write task therefore drives a chosen event vector on the very edge that takes the write, and checks that only the bits without an event were cleared. The encoder's ordering is checked by posting every source and then sweeping a mask that uncovers sources from the top down. This moves the lowest pending index across every position, including the case where nothing is pending. Further arithmetic mask patterns are applied over a partly posted vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W        = 8;
  localparam int GROUPS_DEF    = 3;
  localparam int LAST_BITS_DEF = 6;
  localparam int MODE_BIT      = 7;

  localparam logic [7:0] STATUS_BASE    = 8'hDA;
  localparam logic [7:0] CTRL_ADDR      = 8'hDE;
  localparam logic [7:0] MASK_LAST_ADDR = 8'hDF;
  localparam logic [7:0] MASK_LOW_BASE  = 8'hE0;

  function automatic logic [7:0] status_addr(int g);
    return STATUS_BASE + 8'(g);
  endfunction

  function automatic logic [7:0] mask_addr(int g, int ngroups);
    return (g == ngroups - 1) ? MASK_LAST_ADDR : MASK_LOW_BASE + 8'(g);
  endfunction

  function automatic logic [DATA_W-1:0] group_valid(int g, int ngroups, int last_bits);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (g != ngroups - 1 || b < last_bits) v[b] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/intc_reg_decode.sv
module intc_reg_decode
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = GROUPS_DEF
) (
  input  logic                  reg_wr,
  input  logic [7:0]            reg_addr,
  output logic [NUM_GROUPS-1:0] status_we,
  output logic [NUM_GROUPS-1:0] mask_we,
  output logic                  ctrl_we
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign status_we[g] = reg_wr && (reg_addr == status_addr(g));
    assign mask_we[g]   = reg_wr && (reg_addr == mask_addr(g, NUM_GROUPS));
  end
  assign ctrl_we = reg_wr && (reg_addr == CTRL_ADDR);
endmodule

// File: rtl/intc_post_group.sv
module intc_post_group
  import intc_pkg::*;
#(
  parameter logic [DATA_W-1:0] VALID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              status_we,
  input  logic              sw_mode,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_ev,
  output logic [DATA_W-1:0] posted
);
  logic unused_rsvd;
  assign unused_rsvd = ^{hw_ev & ~VALID, wdata & ~VALID};

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (VALID[b]) begin : g_live
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  flag_q <= 1'b0;
        else if (hw_ev[b])                           flag_q <= 1'b1;
        else if (status_we && sw_mode && wdata[b])   flag_q <= 1'b1;
        else if (status_we && !sw_mode && !wdata[b]) flag_q <= 1'b0;
      end
      assign posted[b] = flag_q;
    end else begin : g_rsvd
      assign posted[b] = 1'b0;
    end
  end
endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS    = GROUPS_DEF,
  parameter int LAST_GRP_BITS = LAST_BITS_DEF
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_GROUPS-1:0]              mask_we,
  input  logic                               ctrl_we,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [NUM_GROUPS-1:0][DATA_W-1:0]  mask,
  output logic                               sw_mode
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    localparam logic [DATA_W-1:0] VALID = group_valid(g, NUM_GROUPS, LAST_GRP_BITS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask[g] <= '0;
      else if (mask_we[g]) mask[g] <= wdata & VALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_mode <= 1'b0;
    else if (ctrl_we) sw_mode <= wdata[MODE_BIT];
  end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int NUM_GROUPS = GROUPS_DEF
) (
  input  logic [7:0]                         reg_addr,
  input  logic [NUM_GROUPS-1:0][DATA_W-1:0]  posted,
  input  logic [NUM_GROUPS-1:0][DATA_W-1:0]  mask,
  input  logic                               sw_mode,
  output logic [DATA_W-1:0]                  rdata
);
  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (reg_addr == status_addr(g))            rdata = posted[g];
      if (reg_addr == mask_addr(g, NUM_GROUPS))  rdata = mask[g];
    end
    if (reg_addr == CTRL_ADDR) begin
      rdata           = '0;
      rdata[MODE_BIT] = sw_mode;
    end
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N     = 22,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             any_q,
  output logic [IDX_W-1:0] idx_q
);
  logic             hit;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      idx_q <= '0;
    end else begin
      any_q <= hit;
      idx_q <= idx;
    end
  end
endmodule

// File: rtl/intc_post_mask.sv
module intc_post_mask
  import intc_pkg::*;
#(
  parameter int  NUM_GROUPS    = GROUPS_DEF,
  parameter int  LAST_GRP_BITS = LAST_BITS_DEF,
  localparam int NUM_SRC       = (NUM_GROUPS - 1) * DATA_W + LAST_GRP_BITS,
  localparam int IDX_W         = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [NUM_SRC-1:0] hw_event,
  output logic [NUM_SRC-1:0] pending,
  output logic               irq_any,
  output logic [IDX_W-1:0]   irq_index
);
  localparam int PAD_W = NUM_GROUPS * DATA_W;

  logic [NUM_GROUPS-1:0]             status_we;
  logic [NUM_GROUPS-1:0]             mask_we;
  logic                              ctrl_we;
  logic                              sw_mode;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] mask_grp;
  logic [NUM_GROUPS-1:0][DATA_W-1:0] posted_grp;
  logic [PAD_W-1:0]                  ev_pad;
  logic [PAD_W-1:0]                  posted_pad;
  logic [PAD_W-1:0]                  mask_pad;
  logic [NUM_SRC-1:0]                posted_flat;
  logic                              unused_pad;

  always_comb begin
    ev_pad                = '0;
    ev_pad[NUM_SRC-1:0]   = hw_event;
  end

  intc_reg_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .status_we (status_we),
    .mask_we   (mask_we),
    .ctrl_we   (ctrl_we)
  );

  intc_mask_bank #(.NUM_GROUPS(NUM_GROUPS), .LAST_GRP_BITS(LAST_GRP_BITS)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (mask_we),
    .ctrl_we (ctrl_we),
    .wdata   (reg_wdata),
    .mask    (mask_grp),
    .sw_mode (sw_mode)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    intc_post_group #(.VALID(group_valid(g, NUM_GROUPS, LAST_GRP_BITS))) u_post (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_we (status_we[g]),
      .sw_mode   (sw_mode),
      .wdata     (reg_wdata),
      .hw_ev     (ev_pad[g*DATA_W +: DATA_W]),
      .posted    (posted_grp[g])
    );
  end

  assign posted_pad  = posted_grp;
  assign mask_pad    = mask_grp;
  assign posted_flat = posted_pad[NUM_SRC-1:0];
  assign pending     = posted_flat & mask_pad[NUM_SRC-1:0];
  assign unused_pad  = ^{posted_pad, mask_pad};

  intc_read_mux #(.NUM_GROUPS(NUM_GROUPS)) u_rd (
    .reg_addr (reg_addr),
    .posted   (posted_grp),
    .mask     (mask_grp),
    .sw_mode  (sw_mode),
    .rdata    (reg_rdata)
  );

  intc_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (pending),
    .any_q (irq_any),
    .idx_q (irq_index)
  );
endmodule

// File: rtl/intc_post_mask_checker.sv
module intc_post_mask_checker
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 22,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [7:0]         reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata,
  input logic [NUM_SRC-1:0] hw_event,
  input logic [NUM_SRC-1:0] pending,
  input logic               irq_any,
  input logic [IDX_W-1:0]   irq_index,
  input logic [NUM_SRC-1:0] posted,
  input logic               swen
);
  logic [NUM_SRC-1:0] pend_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pending;
  end

  assert_event_posts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> ((posted & $past(hw_event)) == $past(hw_event)));

  assert_clear_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STATUS_BASE && !swen) |=>
      ((posted[7:0] & ~$past(reg_wdata) & ~$past(hw_event[7:0])) == 8'h00));

  assert_post_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STATUS_BASE && swen) |=>
      ((posted[7:0] & $past(reg_wdata)) == $past(reg_wdata)));

  assert_ctrl_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_ADDR) |-> (reg_rdata[6:0] == 7'h00));

  assert_rsvd_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == STATUS_BASE + 8'd2 || reg_addr == MASK_LAST_ADDR) |-> (reg_rdata[7:6] == 2'b00));

  assert_any_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (pend_q != '0));

  assert_lowest_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (pend_q[irq_index] &&
                 ((pend_q & ((NUM_SRC'(1) << irq_index) - NUM_SRC'(1))) == '0)));

  assert_read_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && hw_event == '0) |=> $stable(posted) && $stable(swen));
endmodule

bind intc_post_mask intc_post_mask_checker #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .hw_event  (hw_event),
  .pending   (pending),
  .irq_any   (irq_any),
  .irq_index (irq_index),
  .posted    (posted_flat),
  .swen      (sw_mode)
);

// File: tb/intc_post_mask_bench.sv
module intc_post_mask_bench;
  localparam int NS = 22;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic [NS-1:0] hw_event;
  logic [NS-1:0] pending;
  logic          irq_any;
  logic [4:0]    irq_index;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [NS-1:0] m_post;
  logic [NS-1:0] m_mask;
  logic          m_swen;

  always #10 clk = ~clk;

  intc_post_mask u_intc_post_mask (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_event(hw_event),
    .pending(pending), .irq_any(irq_any), .irq_index(irq_index)
  );

  function automatic logic [7:0] gvalid(int g);
    return (g == 2) ? 8'h3F : 8'hFF;
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] a);
    logic [23:0] p;
    logic [23:0] m;
    p = {2'b00, m_post};
    m = {2'b00, m_mask};
    for (int g = 0; g < 3; g++) if (a == 8'(8'hDA + g)) return p[g*8 +: 8];
    if (a == 8'hE0) return m[7:0];
    if (a == 8'hE1) return m[15:8];
    if (a == 8'hDF) return m[23:16];
    if (a == 8'hDE) return {m_swen, 7'b0};
    return 8'h00;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ev(logic [7:0] a, logic [7:0] d, logic [NS-1:0] ev);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; hw_event = ev;
    for (int g = 0; g < 3; g++) begin
      if (a == 8'(8'hDA + g)) begin
        for (int b = 0; b < 8; b++) begin
          if (gvalid(g)[b]) begin
            if (m_swen && d[b])        m_post[g*8+b] = 1'b1;
            else if (!m_swen && !d[b]) m_post[g*8+b] = 1'b0;
          end
        end
      end
    end
    if (a == 8'hE0) m_mask[7:0]   = d;
    if (a == 8'hE1) m_mask[15:8]  = d;
    if (a == 8'hDF) m_mask[21:16] = d[5:0];
    if (a == 8'hDE) m_swen        = d[7];
    m_post = m_post | ev;
    cyc();
    reg_wr = 1'b0; hw_event = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_ev(a, d, '0);
  endtask

  task automatic pulse(logic [NS-1:0] ev);
    hw_event = ev;
    m_post = m_post | ev;
    cyc();
    hw_event = '0;
  endtask

  task automatic rd(logic [7:0] a, string req);
    reg_addr = a;
    #1;
    check(req, $sformatf("read %02h", a), reg_rdata, model_read(a));
  endtask

  task automatic set_masks(logic [NS-1:0] m);
    wr(8'hE0, m[7:0]);
    wr(8'hE1, m[15:8]);
    wr(8'hDF, {2'b00, m[21:16]});
  endtask

  task automatic check_irq(string req);
    logic [NS-1:0] p;
    int lo;
    p = m_post & m_mask;
    check(req, "pending", pending, p);
    cyc();
    lo = -1;
    for (int i = NS - 1; i >= 0; i--) if (p[i]) lo = i;
    check(req, "irq_any", irq_any, (lo >= 0));
    if (lo >= 0) check(req, "irq_index", irq_index, lo);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00; hw_event = '0;
    m_post = '0; m_mask = '0; m_swen = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1: reset state
    check("R1", "pending", pending, 0);
    check("R1", "irq_any", irq_any, 0);
    for (int g = 0; g < 3; g++) rd(8'(8'hDA + g), "R1");
    rd(8'hDE, "R1"); rd(8'hDF, "R1"); rd(8'hE0, "R1"); rd(8'hE1, "R1");

    // R8: every address, unmapped ones read zero
    for (int a = 0; a < 256; a++) rd(8'(a), "R8");

    // R2 and R4: each source posts with mask off, then is cleared by a zero
    for (int i = 0; i < NS; i++) begin
      pulse(NS'(1) << i);
      rd(8'(8'hDA + i / 8), "R2");
      check("R2", "pending masked", pending, 0);
      wr(8'(8'hDA + i / 8), ~(8'h01 << (i % 8)));
      rd(8'(8'hDA + i / 8), "R4");
    end

    // R8: reserved mask bits of group 2
    wr(8'hDF, 8'hFF);
    rd(8'hDF, "R8");
    check("R8", "mask group2 value", reg_rdata, 8'h3F);
    wr(8'hDF, 8'h00);

    // R3 and R9: everything posted, mask uncovers sources from the top
    pulse('1);
    for (int j = 0; j <= NS; j++) begin
      set_masks((j == NS) ? '0 : ('1 << j));
      rd(8'hE0, "R3");
      check_irq("R9");
    end

    // R3 and R9: arithmetic patterns over a partly posted vector
    wr(8'hDA, 8'h00); wr(8'hDB, 8'h00); wr(8'hDC, 8'h00);
    for (int k = 1; k < 17; k++) begin
      logic [31:0] h;
      h = 32'(k) * 32'h9E3779B1;
      pulse(NS'(h >> 3));
      set_masks(NS'(h >> 9) | NS'(h));
      check_irq("R3");
      wr(8'(8'hDA + k % 3), 8'(h >> 13));
      check_irq("R9");
    end

    // R4: ones written with mode off change nothing
    pulse('1);
    wr(8'hDA, 8'hFF);
    rd(8'hDA, "R4");
    wr(8'hDB, 8'hF0);
    rd(8'hDB, "R4");
    wr(8'hDC, 8'h00);
    rd(8'hDC, "R4");

    // R6: mode bit in bit 7 only
    wr(8'hDE, 8'h7F);
    rd(8'hDE, "R6");
    wr(8'hDE, 8'hFF);
    rd(8'hDE, "R6");
    check("R6", "ctrl value", reg_rdata, 8'h80);

    // R5: software posting, zeros ignored; R8 reserved not postable
    foreach (m_post[i]) begin end
    for (int g = 0; g < 3; g++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] d;
        d = (p == 0) ? 8'h01 : (p == 1) ? 8'h80 : (p == 2) ? 8'hA5 : 8'h00;
        wr(8'(8'hDA + g), d);
        rd(8'(8'hDA + g), "R5");
      end
    end
    wr(8'hDC, 8'hC0);
    rd(8'hDC, "R8");
    set_masks('1);
    check_irq("R5");

    // R7: event beats a clear in the same cycle
    wr(8'hDE, 8'h00);
    pulse('1);
    wr_ev(8'hDA, 8'h00, NS'(8'h08));
    rd(8'hDA, "R7");
    check("R7", "group0 value", reg_rdata, 8'h08);
    wr_ev(8'hDC, 8'h00, NS'(1) << 21);
    rd(8'hDC, "R7");
    check("R7", "group2 value", reg_rdata, 8'h20);

    // R10: repeated reads leave all state as it was
    for (int a = 0; a < 256; a++) begin
      reg_addr = 8'(a);
      cyc();
    end
    for (int g = 0; g < 3; g++) rd(8'(8'hDA + g), "R10");
    rd(8'hDE, "R10"); rd(8'hDF, "R10"); rd(8'hE0, "R10"); rd(8'hE1, "R10");
    check_irq("R10");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule